// File: doc/BRIEF.md
# Sync-Referenced Clamp Pulse Generator

This block produces the clamp-active strobe for a video input front end. It watches a raw horizontal sync line and marks the leading edge of each sync pulse; which transition counts as the leading edge is picked by an input-polarity control. From that edge an internal timer waits a programmable number of pixel clocks and then holds the clamp output for a programmable number of pixel clocks. A source-select control can instead route an external clamp line, with selectable active level, straight to the clamp output.

A coast input, with its own polarity control, masks sync edges. While coast is active, leading edges start nothing, and the timer does not react to them. The block also returns the horizontal sync with a chosen output polarity and the vertical sync either passed straight through or inverted. The raw sync, coast and clamp lines all cross into the pixel-clock domain through a two-stage synchronizer. The control inputs are captured in a register that loads every clock and takes its default values in reset.

Top module: `clamp_pulse_gen`

## Requirements
- R1: With `cfg_hs_in_pol`=0 the sync is active low: a 1-to-0 step of `hsync_in` is the leading edge, and a 0-to-1 step never starts a clamp.
- R2: With `cfg_hs_in_pol`=1 the sync is active high: a 0-to-1 step of `hsync_in` is the leading edge, and a 1-to-0 step never starts a clamp.
- R3: With `cfg_clamp_src`=0 and duration D>0, a leading edge driven onto `hsync_in` just before rising clock edge 1 makes `clamp_out` high after rising edges P+3 through P+D+2 and low again after edge P+D+3, where P=`cfg_place` and D=`cfg_dur`. With D=0 no clamp pulse appears.
- R4: A leading edge that arrives while the place or clamp count is running restarts the sequence, timed from the new edge. The earlier edge then produces no pulse.
- R5: With `cfg_clamp_src`=1, `clamp_out` follows `ext_clamp_in` two clocks later: it is high when `ext_clamp_in` is high if `cfg_clamp_pol`=0, and high when `ext_clamp_in` is low if `cfg_clamp_pol`=1.
- R6: A leading edge is ignored while coast is active. Coast is active while `coast_in` equals `cfg_coast_pol` (1 means active high, 0 means active low).
- R7: Two clocks after the inputs change, `hsync_out` is 1 during the active sync phase when `cfg_hs_out_pol`=1 and 0 during it when `cfg_hs_out_pol`=0. `vsync_out` equals `vsync_in` when `cfg_vs_out_inv`=0 and its inverse when `cfg_vs_out_inv`=1.
- R8: While `rst_n` is low, the captured controls hold their defaults (hs_in_pol=1, coast_pol=1, clamp_src=0, clamp_pol=1, hs_out_pol=1, vs_out_inv=1, place=0, dur=0) and `clamp_out` is 0. After reset, a control input takes effect one clock after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| coast_in | input | 1 | Raw coast request |
| ext_clamp_in | input | 1 | Raw external clamp line |
| cfg_hs_in_pol | input | 1 | 1: sync active high, 0: active low |
| cfg_coast_pol | input | 1 | 1: coast active high, 0: active low |
| cfg_clamp_src | input | 1 | 0: internal timer, 1: external line |
| cfg_clamp_pol | input | 1 | 0: clamp while external high, 1: while low |
| cfg_hs_out_pol | input | 1 | 1: hsync_out high in the active phase |
| cfg_vs_out_inv | input | 1 | 1: invert vsync_out |
| cfg_place | input | CNT_W | Delay from leading edge to clamp, in clocks |
| cfg_dur | input | CNT_W | Clamp length, in clocks |
| hsync_out | output | 1 | Polarity-adjusted horizontal sync |
| vsync_out | output | 1 | Optionally inverted vertical sync |
| clamp_out | output | 1 | Clamp active |

## Verification
The timer is swept over placements {0,1,5} and durations {0,1,4} for both sync polarities. Each run compares every clock of the clamp window, which exposes off-by-one errors at the start and at the end. The same sweep also drives the trailing sync transition, which separates an edge detector that reacts to the wrong step from a correct one. Coast is tried at both of its polarities, in both the masking and the pass state, and a retriggered edge during placement shows whether the sequence restarts or runs out from the first edge. The external path is checked for all four combinations of line level and polarity, and the two sync outputs for every combination of their controls.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

   typedef struct packed {
      logic hs_in_pol;
      logic coast_pol;
      logic clamp_src;
      logic clamp_pol;
      logic hs_out_pol;
      logic vs_out_inv;
   } clamp_flags_t;

   localparam clamp_flags_t FLAGS_RST = '{
      hs_in_pol:  1'b1,
      coast_pol:  1'b1,
      clamp_src:  1'b0,
      clamp_pol:  1'b1,
      hs_out_pol: 1'b1,
      vs_out_inv: 1'b1
   };

   typedef enum logic [1:0] {
      TMR_IDLE = 2'd0,
      TMR_WAIT = 2'd1,
      TMR_HOLD = 2'd2
   } tmr_state_t;

endpackage

// File: rtl/clamp_sync.sv
module clamp_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("clamp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/clamp_lead_det.sv
module clamp_lead_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic act_high,
   input  logic mask,
   output logic act,
   output logic lead
);
   logic act_q;

   assign act = lvl ~^ act_high;

   always_ff @(posedge clk) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end

   assign lead = act & ~act_q & ~mask;
endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
   import clamp_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] place,
   input  logic [CNT_W-1:0] dur,
   output logic             clamp,
   output logic             busy
);
   generate
      if (CNT_W < 1) begin : g_bad
         $error("clamp_timer: CNT_W must be positive");
      end
   endgenerate

   tmr_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] dur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= TMR_IDLE;
         cnt   <= '0;
         dur_q <= '0;
         clamp <= 1'b0;
      end else if (start) begin
         dur_q <= dur;
         if (dur == '0) begin
            st    <= TMR_IDLE;
            cnt   <= '0;
            clamp <= 1'b0;
         end else if (place == '0) begin
            st    <= TMR_HOLD;
            cnt   <= dur - 1'b1;
            clamp <= 1'b1;
         end else begin
            st    <= TMR_WAIT;
            cnt   <= place - 1'b1;
            clamp <= 1'b0;
         end
      end else begin
         unique case (st)
            TMR_WAIT: begin
               if (cnt == '0) begin
                  st    <= TMR_HOLD;
                  cnt   <= dur_q - 1'b1;
                  clamp <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            TMR_HOLD: begin
               if (cnt == '0) begin
                  st    <= TMR_IDLE;
                  clamp <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               st    <= TMR_IDLE;
               clamp <= 1'b0;
            end
         endcase
      end
   end

   assign busy = (st != TMR_IDLE);
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
   import clamp_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_in,
   input  logic             vsync_in,
   input  logic             coast_in,
   input  logic             ext_clamp_in,
   input  logic             cfg_hs_in_pol,
   input  logic             cfg_coast_pol,
   input  logic             cfg_clamp_src,
   input  logic             cfg_clamp_pol,
   input  logic             cfg_hs_out_pol,
   input  logic             cfg_vs_out_inv,
   input  logic [CNT_W-1:0] cfg_place,
   input  logic [CNT_W-1:0] cfg_dur,
   output logic             hsync_out,
   output logic             vsync_out,
   output logic             clamp_out
);
   localparam int NSIG = 4;

   clamp_flags_t     flags_q;
   logic [CNT_W-1:0] place_q;
   logic [CNT_W-1:0] dur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= FLAGS_RST;
         place_q <= '0;
         dur_q   <= '0;
      end else begin
         flags_q <= '{
            hs_in_pol:  cfg_hs_in_pol,
            coast_pol:  cfg_coast_pol,
            clamp_src:  cfg_clamp_src,
            clamp_pol:  cfg_clamp_pol,
            hs_out_pol: cfg_hs_out_pol,
            vs_out_inv: cfg_vs_out_inv
         };
         place_q <= cfg_place;
         dur_q   <= cfg_dur;
      end
   end

   logic [NSIG-1:0] raw_vec, syn_vec;
   logic hs_s, vs_s, coast_s, ext_s;

   assign raw_vec = {hsync_in, vsync_in, coast_in, ext_clamp_in};

   clamp_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_vec),
      .q     (syn_vec)
   );

   assign {hs_s, vs_s, coast_s, ext_s} = syn_vec;

   logic coast_act;
   logic hs_act;
   logic lead_pulse;

   assign coast_act = coast_s ~^ flags_q.coast_pol;

   clamp_lead_det u_lead (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (hs_s),
      .act_high (flags_q.hs_in_pol),
      .mask     (coast_act),
      .act      (hs_act),
      .lead     (lead_pulse)
   );

   logic tmr_clamp;
   logic tmr_busy;

   clamp_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (lead_pulse),
      .place (place_q),
      .dur   (dur_q),
      .clamp (tmr_clamp),
      .busy  (tmr_busy)
   );

   logic ext_clamp_act;
   assign ext_clamp_act = ext_s ^ flags_q.clamp_pol;

   assign clamp_out = flags_q.clamp_src ? ext_clamp_act : tmr_clamp;
   assign hsync_out = hs_act ~^ flags_q.hs_out_pol;
   assign vsync_out = vs_s ^ flags_q.vs_out_inv;
endmodule

// File: rtl/clamp_pulse_chk.sv
module clamp_pulse_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vsync_in,
   input logic             ext_clamp_in,
   input logic             vsync_out,
   input logic             clamp_out,
   input logic             lead_pulse,
   input logic             tmr_clamp,
   input logic             tmr_busy,
   input logic             coast_act,
   input logic             src_q,
   input logic             clamp_pol_q,
   input logic             vs_inv_q,
   input logic [CNT_W-1:0] place_q,
   input logic [CNT_W-1:0] dur_q
);
   logic [1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n)        age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   a_r3_zero_dur: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_pulse && dur_q == '0) |=> !tmr_clamp);

   a_r3_zero_place: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_pulse && dur_q != '0 && place_q == '0) |=> tmr_clamp);

   a_r6_coast_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (coast_act && !tmr_busy) |=> !tmr_busy);

   a_r5_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && src_q) |-> (clamp_out == ($past(ext_clamp_in, 2) ^ clamp_pol_q)));

   a_r7_vsync: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (vsync_out == ($past(vsync_in, 2) ^ vs_inv_q)));

   a_r8_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !tmr_clamp);
endmodule

bind clamp_pulse_gen clamp_pulse_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .vsync_in     (vsync_in),
   .ext_clamp_in (ext_clamp_in),
   .vsync_out    (vsync_out),
   .clamp_out    (clamp_out),
   .lead_pulse   (lead_pulse),
   .tmr_clamp    (tmr_clamp),
   .tmr_busy     (tmr_busy),
   .coast_act    (coast_act),
   .src_q        (flags_q.clamp_src),
   .clamp_pol_q  (flags_q.clamp_pol),
   .vs_inv_q     (flags_q.vs_out_inv),
   .place_q      (place_q),
   .dur_q        (dur_q)
);

// File: tb/tb_clamp_pulse_gen.sv
module tb_clamp_pulse_gen;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_in = 1'b0, vsync_in = 1'b0, coast_in = 1'b0, ext_clamp_in = 1'b0;
   logic cfg_hs_in_pol = 1'b0, cfg_coast_pol = 1'b1, cfg_clamp_src = 1'b1;
   logic cfg_clamp_pol = 1'b0, cfg_hs_out_pol = 1'b0, cfg_vs_out_inv = 1'b0;
   logic [CNT_W-1:0] cfg_place = '0, cfg_dur = '0;
   logic hsync_out, vsync_out, clamp_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clamp_pulse_gen #(.CNT_W(CNT_W)) dut (.*);

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drive a leading edge, sample the full window, then the trailing edge
   task automatic pulse_run(input bit pol, input int p, input int d,
                            input bit cpol, input bit cin, input string tag);
      int bad = 0, bad_j = 0, bad_v = 0, bad_e = 0;
      bit masked;
      masked = (cin == cpol);
      cfg_clamp_src = 1'b0;
      cfg_hs_in_pol = pol;
      cfg_coast_pol = cpol;
      coast_in      = cin;
      cfg_place     = CNT_W'(p);
      cfg_dur       = CNT_W'(d);
      hsync_in      = ~pol;
      settle(20);
      hsync_in = pol;
      for (int j = 1; j <= p + d + 6; j++) begin
         bit e;
         @(negedge clk);
         e = !masked && d > 0 && j >= p + 3 && j <= p + d + 2;
         if (clamp_out !== e && bad == 0) begin
            bad = 1; bad_j = j; bad_v = int'(clamp_out); bad_e = int'(e);
         end
      end
      check(bad == 0, $sformatf("%s window pol=%0d P=%0d D=%0d j=%0d", tag, pol, p, d, bad_j),
            bad_v, bad_e);
      // trailing transition must not start anything
      bad = 0;
      hsync_in = ~pol;
      for (int j = 1; j <= p + d + 6; j++) begin
         @(negedge clk);
         if (clamp_out !== 1'b0) bad = 1;
      end
      check(bad == 0, $sformatf("%s trailing edge ignored pol=%0d P=%0d D=%0d",
            pol ? "R2" : "R1", pol, p, d), bad, 0);
   endtask

   initial begin
      int pl[3] = '{0, 1, 5};
      int du[3] = '{0, 1, 4};
      settle(3);
      // R8: defaults in reset despite non-default control inputs
      check(vsync_out === 1'b1, "R8 vsync_out in reset", int'(vsync_out), 1);
      check(hsync_out === 1'b0, "R8 hsync_out in reset", int'(hsync_out), 0);
      check(clamp_out === 1'b0, "R8 clamp_out in reset", int'(clamp_out), 0);
      rst_n = 1'b1;
      settle(4);

      // R1/R2/R3 sweep, coast inactive
      for (int pol = 0; pol < 2; pol++)
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
               pulse_run(pol[0], pl[a], du[b], 1'b1, 1'b0, "R3");

      // R6: coast active high / active low, masking and passing
      for (int pol = 0; pol < 2; pol++) begin
         pulse_run(pol[0], 2, 3, 1'b1, 1'b1, "R6 coast hi active");
         pulse_run(pol[0], 2, 3, 1'b0, 1'b0, "R6 coast lo active");
         pulse_run(pol[0], 2, 3, 1'b0, 1'b1, "R6 coast lo idle");
      end
      coast_in = 1'b0; cfg_coast_pol = 1'b1;

      // R4: retrigger during placement
      begin
         int bad = 0, bad_j = 0;
         cfg_hs_in_pol = 1'b1; cfg_place = 8'd4; cfg_dur = 8'd6;
         hsync_in = 1'b0;
         settle(20);
         hsync_in = 1'b1;
         settle(2);
         hsync_in = 1'b0;
         settle(2);
         hsync_in = 1'b1;
         for (int j = 1; j <= 16; j++) begin
            bit e;
            @(negedge clk);
            e = (j >= 7 && j <= 12);
            if (clamp_out !== e && bad == 0) begin bad = 1; bad_j = j; end
         end
         check(bad == 0, $sformatf("R4 restart window j=%0d", bad_j), bad, 0);
         hsync_in = 1'b0;
         settle(16);
      end

      // R5: external clamp path
      cfg_clamp_src = 1'b1;
      for (int cp = 0; cp < 2; cp++)
         for (int v = 0; v < 2; v++) begin
            cfg_clamp_pol = cp[0];
            ext_clamp_in  = ~v[0];
            settle(4);
            ext_clamp_in = v[0];
            settle(1);
            check(clamp_out === (~v[0] ^ cp[0]), $sformatf("R5 latency hold pol=%0d v=%0d", cp, v),
                  int'(clamp_out), int'(~v[0] ^ cp[0]));
            settle(1);
            check(clamp_out === (v[0] ^ cp[0]), $sformatf("R5 follow pol=%0d v=%0d", cp, v),
                  int'(clamp_out), int'(v[0] ^ cp[0]));
         end
      cfg_clamp_src = 1'b0;

      // R7: sync outputs
      for (int ip = 0; ip < 2; ip++)
         for (int op = 0; op < 2; op++)
            for (int v = 0; v < 2; v++) begin
               bit ex;
               cfg_hs_in_pol = ip[0]; cfg_hs_out_pol = op[0];
               cfg_vs_out_inv = op[0];
               hsync_in = v[0]; vsync_in = v[0];
               settle(3);
               ex = ((v[0] == ip[0]) == op[0]);
               check(hsync_out === ex, $sformatf("R7 hsync ip=%0d op=%0d v=%0d", ip, op, v),
                     int'(hsync_out), int'(ex));
               check(vsync_out === (v[0] ^ op[0]), $sformatf("R7 vsync inv=%0d v=%0d", op, v),
                     int'(vsync_out), int'(v[0] ^ op[0]));
            end

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule